// File: doc/BRIEF.md
# Parallel ROM Read Controller

This block lets logic on a synchronous clock read an asynchronous parallel read-only memory that can be organised either as 16-bit words or as 8-bit bytes. A read request carries an address and a width select. The controller drives the memory's active-low chip enable, output enable and width select, the address lines, and the direction of the memory's shared top pin. That pin returns data bit 15 in word mode and carries the lowest byte-address bit into the memory in byte mode. The controller then waits a number of clock cycles computed from timing parameters, captures the data lines and returns the result.

Each wait count is the ceiling of a required time in nanoseconds divided by the clock period parameter, plus one cycle of margin. The read wait is the larger of the address/enable-to-data count and the output-enable-to-data count. The release wait covers the time the memory's outputs take to float once the memory is disabled. With defaults of 20 ns clock, 150 ns access, 70 ns output enable and 20 ns float, the counts are 9 read cycles and 2 release cycles.

Both sides of the block use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only when no access is in flight. A response is offered with `rsp_valid` and is held, with its data, until the edge where `rsp_ready` is high. No new request is taken until that response has been consumed, so a stalled consumer holds back the request side.

Top module: `rom_rd_ctrl`

## Requirements
- R1: After reset, and whenever idle, `req_ready`=1, `mem_ce_n`=1, `mem_oe_n`=1, `mem_top_oe`=0 and `rsp_valid`=0.
- R2: A word request (`req_byte`=0) puts `req_addr[18:0]` on `mem_addr` with `mem_byte_n`=1, ignores `req_addr[19]`, and returns all 16 data lines on `rsp_data`.
- R3: A byte request (`req_byte`=1) puts `req_addr[19:1]` on `mem_addr`, drives `req_addr[0]` out on the top pin (`mem_top_out`, with `mem_top_oe`=1), sets `mem_byte_n`=0, and returns `{8'h00, data lines 7..0}`. Data lines 15..8 are ignored. The top pin is driven only in byte mode.
- R4: `mem_byte_n` changes only while `mem_ce_n`=1. It is set in a setup cycle with the memory disabled before chip enable is asserted.
- R5: Chip enable and output enable stay low for T_RD = max(ceil(ACC/CLK)+1, ceil(OE/CLK)+1) cycles (9 by default) before the data lines are captured.
- R6: `mem_addr`, `mem_top_out` and `mem_top_oe` stay constant while `mem_ce_n`=0.
- R7: After chip enable is released, at least T_HZ = ceil(HZ/CLK)+1 cycles (2 by default) pass before chip enable falls again or the top pin starts being driven.
- R8: `req_ready` is low from acceptance until the response is consumed. Requests presented during that time are not taken and start no memory access.
- R9: Once `rsp_valid` rises, it and `rsp_data` hold steady until a clock edge with `rsp_ready`=1. `rsp_valid` falls after that edge.
- R10: `mem_oe_n` is low only while `mem_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller idle, will take a request |
| req_addr | input | 20 | Byte address (byte mode) or word address in bits 18..0 (word mode) |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes the data |
| rsp_data | output | 16 | Read result, zero-extended in byte mode |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_byte_n | output | 1 | Memory width select, low = byte mode |
| mem_addr | output | 19 | Memory address lines |
| mem_dq_i | input | 16 | Memory data lines as seen by the controller |
| mem_top_out | output | 1 | Value driven onto the shared top pin (byte address bit 0) |
| mem_top_oe | output | 1 | 1 = controller drives the shared top pin |

## Verification
The assertions assume the consumer and producer follow valid/ready. In particular, the hold check on the response assumes nothing resets mid-transfer. The pin-timing assertions assume the memory never needs more than the parameterised times.

The bench keeps requests within the handshake rules, dropping `req_valid` once a request is taken. It lowers `rsp_ready` only while a response is pending. Its behavioural memory only presents valid data once both enables have been low for the access time, and returns a junk pattern before that. In byte mode it drives junk on lines 15..8. Any early capture, or any read of the upper lines in byte mode, therefore shows up in the returned data.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_REL,
    ST_RESP
  } rd_state_t;

  // ceiling division for elaboration-time cycle counts
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_wait_timer.sv
module rom_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= len;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5: a nonzero load must hold off completion for at least one cycle
  a_r5_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len != '0) |=> !zero);

endmodule

// File: rtl/rom_rd_capture.sv
module rom_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          byte_mode,
  input  logic [DW-1:0] dq,
  output logic [DW-1:0] data
);
  localparam int HW = DW / 2;

  logic [DW-1:0] ext;

  always_comb begin
    if (byte_mode) ext = {{(DW-HW){1'b0}}, dq[HW-1:0]};
    else           ext = dq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data <= '0;
    else if (cap) data <= ext;
  end

  // R3: byte captures are zero-extended
  a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && byte_mode) |=> (data[DW-1:HW] == '0));

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int CLK_NS = 20,
  parameter int ACC_NS = 150,
  parameter int OE_NS  = 70,
  parameter int HZ_NS  = 20,
  parameter int AW     = 19,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW:0]   req_addr,
  input  logic          req_byte,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_byte_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_top_out,
  output logic          mem_top_oe
);
  localparam int T_ACC = cdiv(ACC_NS, CLK_NS) + 1;
  localparam int T_OE  = cdiv(OE_NS, CLK_NS) + 1;
  localparam int T_RD  = imax(T_ACC, T_OE);
  localparam int T_HZ  = cdiv(HZ_NS, CLK_NS) + 1;
  localparam int TW    = $clog2(imax(T_RD, T_HZ) + 1) + 1;

  rd_state_t state;
  logic      tmr_load, tmr_zero, cap;
  logic [TW-1:0] tmr_len;

  wire accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mem_addr    <= '0;
      mem_top_out <= 1'b0;
      mem_top_oe  <= 1'b0;
      mem_byte_n  <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          mem_addr    <= req_byte ? req_addr[AW:1] : req_addr[AW-1:0];
          mem_top_out <= req_addr[0];
          mem_top_oe  <= req_byte;
          mem_byte_n  <= ~req_byte;
          state       <= ST_SETUP;
        end
        ST_SETUP: state <= ST_READ;
        ST_READ: if (tmr_zero) begin
          mem_top_oe <= 1'b0;
          state      <= ST_REL;
        end
        ST_REL:  if (tmr_zero) state <= ST_RESP;
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cap       = (state == ST_READ) && tmr_zero;
  assign tmr_load  = (state == ST_SETUP) || cap;
  assign tmr_len   = (state == ST_SETUP) ? TW'(T_RD - 1) : TW'(T_HZ - 1);
  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign mem_ce_n  = (state != ST_READ);
  assign mem_oe_n  = (state != ST_READ);

  rom_wait_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .zero(tmr_zero)
  );

  rom_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(cap), .byte_mode(~mem_byte_n),
    .dq(mem_dq_i), .data(rsp_data)
  );

  // checker counters: enable-low run length and enable-high gap
  localparam int CW = $clog2(imax(T_RD, T_HZ) + 1) + 1;
  logic [CW-1:0] on_cnt, off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt  <= '0;
      off_cnt <= CW'(T_HZ);
    end else if (!mem_ce_n) begin
      off_cnt <= '0;
      if (on_cnt < CW'(T_RD)) on_cnt <= on_cnt + 1'b1;
    end else begin
      on_cnt <= '0;
      if (off_cnt < CW'(T_HZ)) off_cnt <= off_cnt + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && !mem_top_oe && !rsp_valid));

  a_r3_top_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_top_oe |-> !mem_byte_n);

  a_r4_width_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> $stable(mem_byte_n));

  a_r5_read_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (on_cnt >= CW'(T_RD)));

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> ($stable(mem_addr) && $stable(mem_top_out) && $stable(mem_top_oe)));

  a_r7_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) || $rose(mem_top_oe)) |-> (off_cnt >= CW'(T_HZ)));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r10_oe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);

endmodule

// File: tb/rom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module rom_rd_ctrl_tb;
  localparam int CLK = 20;
  localparam int EXP_RD  = (150 + CLK - 1) / CLK + 1;   // 9
  localparam int EXP_HZ  = (20 + CLK - 1) / CLK + 1;    // 2
  localparam int MDL_ACC = (150 + CLK - 1) / CLK;       // memory valid after 8

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_byte = 0, rsp_ready = 1;
  logic [19:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_byte_n, mem_top_out, mem_top_oe;
  logic [15:0] rsp_data, mem_dq;
  logic [18:0] mem_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  rom_rd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_byte_n(mem_byte_n), .mem_addr(mem_addr),
    .mem_dq_i(mem_dq), .mem_top_out(mem_top_out), .mem_top_oe(mem_top_oe)
  );

  function automatic logic [15:0] mword(input logic [18:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ {5'b0, a[18:16]} ^ 8'h3C};
  endfunction

  function automatic logic [15:0] expect_of(input logic b, input logic [19:0] a);
    logic [15:0] w;
    if (!b) return mword(a[18:0]);
    w = mword(a[19:1]);
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  // behavioural memory and pin-rule monitor
  int mdl_cnt = 0, run = 0, last_run = 0, gap = 100, ce_falls = 0;
  int v_r4 = 0, v_r6 = 0, v_r7 = 0, v_r10 = 0, v_r3 = 0;
  logic p_ce = 1, p_byte = 1, p_toe = 0;
  logic [18:0] p_addr = '0;

  always_comb begin
    logic [15:0] w;
    w = mword(mem_addr);
    if (mem_ce_n || mem_oe_n)  mem_dq = 16'h0000;
    else if (mdl_cnt < MDL_ACC) mem_dq = 16'hBAD0;
    else if (!mem_byte_n) begin
      if (!mem_top_oe) mem_dq = 16'hEEEE;
      else mem_dq = {8'hEE, mem_top_out ? w[15:8] : w[7:0]};
    end else mem_dq = w;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_oe_n) mdl_cnt <= mdl_cnt + 1; else mdl_cnt <= 0;
      if (!mem_ce_n) run <= run + 1;
      else if (!p_ce) begin last_run <= run; run <= 0; end
      if (!mem_ce_n && !p_ce && mem_byte_n != p_byte) v_r4 <= v_r4 + 1;
      if (!mem_ce_n && !p_ce && mem_addr != p_addr) v_r6 <= v_r6 + 1;
      if (!mem_oe_n && mem_ce_n) v_r10 <= v_r10 + 1;
      if (!mem_ce_n && !mem_byte_n && !mem_top_oe) v_r3 <= v_r3 + 1;
      if (mem_top_oe && mem_byte_n) v_r3 <= v_r3 + 1;
      if (((!mem_ce_n && p_ce) || (mem_top_oe && !p_toe)) && gap < EXP_HZ) v_r7 <= v_r7 + 1;
      if (!mem_ce_n && p_ce) ce_falls <= ce_falls + 1;
      if (!mem_ce_n) gap <= 0; else if (gap < 100) gap <= gap + 1;
      p_ce <= mem_ce_n; p_byte <= mem_byte_n; p_addr <= mem_addr; p_toe <= mem_top_oe;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic b, input logic [19:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_byte = b; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    @(negedge clk);
  endtask

  localparam logic [20:0] VEC [8] = '{
    {1'b0, 20'h00000}, {1'b0, 20'hFFFFF}, {1'b1, 20'h00000}, {1'b1, 20'h00001},
    {1'b1, 20'hFFFFF}, {1'b0, 20'h2AAAA}, {1'b1, 20'h12345}, {1'b1, 20'h5555A}
  };

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && mem_ce_n && mem_oe_n && !mem_top_oe && !rsp_valid, "R1 reset",
        {req_ready, mem_ce_n, mem_oe_n, mem_top_oe, rsp_valid}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_ce_n, "R1 idle after reset", {req_ready, mem_ce_n}, 2'b11);

    // R2 / R3 / R5 vector table
    foreach (VEC[i]) begin
      do_read(VEC[i][20], VEC[i][19:0], d);
      chk(d == expect_of(VEC[i][20], VEC[i][19:0]), VEC[i][20] ? "R3 byte data" : "R2 word data",
          d, expect_of(VEC[i][20], VEC[i][19:0]));
      chk(last_run >= EXP_RD, "R5 read wait", last_run, EXP_RD);
      chk(req_ready && mem_ce_n && !mem_top_oe, "R1 idle between", {req_ready, mem_ce_n, mem_top_oe}, 3'b110);
    end

    // R8 requests while busy are not taken
    begin
      int f0;
      bit rdy_seen = 0;
      f0 = ce_falls;
      @(negedge clk);
      req_valid = 1; req_byte = 0; req_addr = 20'h01234;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_addr = 20'h04321; req_byte = 1;
      for (int k = 0; k < 6; k++) begin
        if (req_ready) rdy_seen = 1;
        @(negedge clk);
      end
      req_valid = 0;
      while (!rsp_valid) @(negedge clk);
      chk(!rdy_seen, "R8 ready low while busy", rdy_seen, 0);
      chk(rsp_data == expect_of(0, 20'h01234), "R8 first request kept", rsp_data, expect_of(0, 20'h01234));
      @(negedge clk);
      repeat (4) @(negedge clk);
      chk(ce_falls == f0 + 1, "R8 no extra access", ce_falls - f0, 1);
    end

    // R9 response back-pressure
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_byte = 1; req_addr = 20'h0ABCD;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    begin
      bit held = 1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (!rsp_valid || rsp_data != d || req_ready) held = 0;
      end
      chk(held, "R9 response held", held, 1);
    end
    chk(d == expect_of(1, 20'h0ABCD), "R9 held data", d, expect_of(1, 20'h0ABCD));
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 released after ready", {rsp_valid, req_ready}, 2'b01);

    // R2 word mode ignores address bit 19
    do_read(0, 20'h80055, d);
    chk(d == mword(19'h00055), "R2 bit19 ignored", d, mword(19'h00055));

    // pin-rule monitor results
    chk(v_r4 == 0, "R4 width select changed under enable", v_r4, 0);
    chk(v_r6 == 0, "R6 address changed under enable", v_r6, 0);
    chk(v_r7 == 0, "R7 release gap", v_r7, 0);
    chk(v_r10 == 0, "R10 output enable without chip enable", v_r10, 0);
    chk(v_r3 == 0, "R3 top pin direction", v_r3, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule